// File: doc/BRIEF.md
# Hashed Four-Way SPI-to-SA Index Table

This block translates the security parameter index (SPI) of an inbound IPsec packet into a 32-bit security-association (SA) index. Software often picks SPIs at random, so a direct-indexed table is not practical. Each SPI is therefore qualified by a 16-bit match identifier and a 7-bit logical-function number, and the result is stored in a four-way, hash-indexed key/value memory. A hash of the 55-bit key gives one candidate set in each way.

A serialised valid/ready command port carries three kinds of request: insert (with duplicate detection), delete of a named set and way (with an ownership check), and flush of every entry that belongs to one logical function. Every command ends with a one-cycle response that carries a status, a set index, a way and a duplicate flag. A separate data-path lookup port runs at the same time as the command port. It accepts one key per cycle and returns a hit flag and the SA index two cycles later.

After reset the block sweeps the whole table clear before it accepts its first command, so the memories need no reset of their own.

Top module: `spi_sa_table`

## Requirements
- R1: After reset, rsp_valid and lk_done are 0 and cmd_ready stays 0 for exactly 2^SET_W cycles while every entry is cleared. A lookup afterwards misses.
- R2: The key is {lf[6:0], match[15:0], spi[31:0]}, which places the SPI in bits 31:0, the match identifier in bits 47:32 and the logical function in bits 54:48. Let F[c] be the XOR of all key bits i with i mod 11 = c. The set index of way w then has bit b equal to F[(b+3w) mod 11]. It follows that flipping key bits p and p+11 together leaves every set index unchanged.
- R3: An insert that finds no duplicate writes the first invalid candidate, searching way 0 then 1, 2, 3. rsp_valid rises one cycle after the accepting edge with status 0 (ok), that way, its set and dup=0.
- R4: When a valid candidate holds the same key, an insert writes nothing and returns status 0, dup=1, and that entry's set and way.
- R5: When all four candidates are valid and none matches, an insert writes nothing and returns status 1 (full), the way-0 set and way 0.
- R6: A delete (op 1) names cmd_set and cmd_way. If the stored logical function differs from cmd_lf, the delete returns status 2 (not owner) and leaves the entry intact. Otherwise it clears the entry and returns status 0.
- R7: A flush (op 2) of cmd_lf clears every entry whose stored logical function equals cmd_lf and keeps all other entries. It visits one set per cycle and responds with status 0 exactly 2^SET_W cycles after acceptance.
- R8: A lookup presented with lk_valid sets lk_done exactly two cycles later. lk_hit shows whether a valid entry with the full key exists, and lk_sa gives its SA index on a hit or 0 on a miss.
- R9: A lookup sampled on the same edge at which a command writes the table sees the contents from before that write. A lookup sampled one cycle later sees the new contents.
- R10: Commands are serialised. cmd_ready drops after an acceptance and returns with the single-cycle response.
- R11: Op code 3 changes nothing and returns status 3 (bad op).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 insert, 1 delete, 2 flush, 3 invalid |
| cmd_spi | input | 32 | SPI of the key |
| cmd_match | input | 16 | Match identifier of the key |
| cmd_lf | input | 7 | Logical function of the requester |
| cmd_sa | input | 32 | SA index to store on insert |
| cmd_set | input | 11 | Set index for delete |
| cmd_way | input | 2 | Way for delete |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 full, 2 not owner, 3 bad op |
| rsp_set | output | 11 | Set index of the affected entry |
| rsp_way | output | 2 | Way of the affected entry |
| rsp_dup | output | 1 | Insert found an existing equal key |
| lk_valid | input | 1 | Lookup request |
| lk_spi | input | 32 | Lookup SPI |
| lk_match | input | 16 | Lookup match identifier |
| lk_lf | input | 7 | Lookup logical function |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found the key |
| lk_sa | output | 32 | SA index on hit, else 0 |

## Verification
A data-path lookup and a command write can land on the same clock edge, because the lookup port never stalls. The bench makes this happen on purpose. It releases an insert of a key that is not yet in the table and presents a lookup of that same key on the edge that performs the write, then presents it again on the next edge. The first result must be a miss and the second a hit carrying the new SA index. Colliding keys built from the bit-pair rule of R2 fill all four ways of one set, so the duplicate, full, first-free and delete cases are exercised on a single, known set.

// File: rtl/spi_sa_pkg.sv
package spi_sa_pkg;
  localparam int SPI_W = 32;
  localparam int MID_W = 16;
  localparam int LF_W  = 7;
  localparam int SA_W  = 32;
  localparam int KEY_W = LF_W + MID_W + SPI_W;

  localparam logic [1:0] OP_INS   = 2'd0;
  localparam logic [1:0] OP_DEL   = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_FULL  = 2'd1;
  localparam logic [1:0] ST_OWNER = 2'd2;
  localparam logic [1:0] ST_BADOP = 2'd3;

  typedef struct packed {
    logic             valid;
    logic [LF_W-1:0]  lf;
    logic [MID_W-1:0] mid;
    logic [SPI_W-1:0] spi;
  } key_t;
endpackage

// File: rtl/spi_sa_hash.sv
module spi_sa_hash #(
  parameter int KEY_W = 55,
  parameter int SET_W = 11,
  parameter int WAYS  = 4
) (
  input  logic [KEY_W-1:0]            key,
  output logic [WAYS-1:0][SET_W-1:0]  sets
);
  logic [SET_W-1:0] fold;

  // fold every key bit into the residue class of its position
  always_comb begin
    fold = '0;
    for (int i = 0; i < KEY_W; i++) fold[i % SET_W] = fold[i % SET_W] ^ key[i];
  end

  // each way takes a different rotation of the folded word
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    for (genvar b = 0; b < SET_W; b++) begin : g_bit
      assign sets[w][b] = fold[(b + 3 * w) % SET_W];
    end
  end
endmodule

// File: rtl/spi_sa_way.sv
module spi_sa_way #(
  parameter int AW = 11,
  parameter int KW = 56,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [KW-1:0] wkey,
  input  logic [VW-1:0] wval,
  input  logic [AW-1:0] ra_addr,
  output logic [KW-1:0] ra_key,
  input  logic [AW-1:0] rb_addr,
  output logic [KW-1:0] rb_key,
  output logic [VW-1:0] rb_val
);
  localparam int DEPTH = 1 << AW;

  logic [KW-1:0] key_mem [DEPTH];
  logic [VW-1:0] val_mem [DEPTH];

  // read-before-write: reads on the write edge return old contents
  always_ff @(posedge clk) begin
    if (we) begin
      key_mem[waddr] <= wkey;
      val_mem[waddr] <= wval;
    end
    ra_key <= key_mem[ra_addr];
    rb_key <= key_mem[rb_addr];
    rb_val <= val_mem[rb_addr];
  end
endmodule

// File: rtl/spi_sa_table.sv
module spi_sa_table
  import spi_sa_pkg::*;
#(
  parameter int SET_W = 11,
  parameter int WAYS  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cmd_valid,
  output logic                            cmd_ready,
  input  logic [1:0]                      cmd_op,
  input  logic [SPI_W-1:0]                cmd_spi,
  input  logic [MID_W-1:0]                cmd_match,
  input  logic [LF_W-1:0]                 cmd_lf,
  input  logic [SA_W-1:0]                 cmd_sa,
  input  logic [SET_W-1:0]                cmd_set,
  input  logic [$clog2(WAYS)-1:0]         cmd_way,
  output logic                            rsp_valid,
  output logic [1:0]                      rsp_status,
  output logic [SET_W-1:0]                rsp_set,
  output logic [$clog2(WAYS)-1:0]         rsp_way,
  output logic                            rsp_dup,
  input  logic                            lk_valid,
  input  logic [SPI_W-1:0]                lk_spi,
  input  logic [MID_W-1:0]                lk_match,
  input  logic [LF_W-1:0]                 lk_lf,
  output logic                            lk_done,
  output logic                            lk_hit,
  output logic [SA_W-1:0]                 lk_sa
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT_W = $bits(key_t);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_CHECK, S_FLUSH} state_t;

  state_t                    state;
  logic [SET_W-1:0]          rd_ptr;
  logic [1:0]                op_q;
  logic [LF_W-1:0]           lf_q;
  logic [MID_W-1:0]          mid_q;
  logic [SPI_W-1:0]          spi_q;
  logic [SA_W-1:0]           sa_q;
  logic [WAY_W-1:0]          way_q;
  logic [WAYS-1:0][SET_W-1:0] sets_q, cmd_sets, lk_sets, ra;

  logic [WAYS-1:0]           we;
  logic [WAYS-1:0][SET_W-1:0] waddr;
  key_t [WAYS-1:0]           wkey, qa, qb;
  logic [WAYS-1:0][SA_W-1:0] wval, qb_val;

  spi_sa_hash #(.KEY_W(KEY_W), .SET_W(SET_W), .WAYS(WAYS)) u_cmd_hash (
    .key({cmd_lf, cmd_match, cmd_spi}), .sets(cmd_sets));
  spi_sa_hash #(.KEY_W(KEY_W), .SET_W(SET_W), .WAYS(WAYS)) u_lk_hash (
    .key({lk_lf, lk_match, lk_spi}), .sets(lk_sets));

  for (genvar w = 0; w < WAYS; w++) begin : g_mem
    spi_sa_way #(.AW(SET_W), .KW(ENT_W), .VW(SA_W)) u_way (
      .clk(clk), .we(we[w]), .waddr(waddr[w]), .wkey(wkey[w]), .wval(wval[w]),
      .ra_addr(ra[w]), .ra_key(qa[w]), .rb_addr(lk_sets[w]), .rb_key(qb[w]),
      .rb_val(qb_val[w]));
  end

  // candidate evaluation for the command being checked
  logic [WAYS-1:0]  dup_vec, free_vec;
  logic             dup_any, free_any, owner_ok;
  logic [WAY_W-1:0] dup_idx, free_idx;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      dup_vec[w]  = qa[w].valid && qa[w].lf == lf_q && qa[w].mid == mid_q && qa[w].spi == spi_q;
      free_vec[w] = !qa[w].valid;
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (dup_vec[w])  dup_idx  = WAY_W'(w);
      if (free_vec[w]) free_idx = WAY_W'(w);
    end
    dup_any  = |dup_vec;
    free_any = |free_vec;
    owner_ok = qa[way_q].lf == lf_q;
  end

  assign cmd_ready = (state == S_IDLE);

  // read and write port steering per way
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      case (state)
        S_IDLE:  ra[w] = (cmd_op == OP_DEL) ? cmd_set :
                         (cmd_op == OP_FLUSH) ? '0 : cmd_sets[w];
        S_FLUSH: ra[w] = rd_ptr + SET_W'(1);
        default: ra[w] = sets_q[w];
      endcase
      we[w]    = 1'b0;
      waddr[w] = sets_q[w];
      wkey[w]  = '0;
      wval[w]  = '0;
      case (state)
        S_INIT: begin
          we[w]    = 1'b1;
          waddr[w] = rd_ptr;
        end
        S_CHECK: begin
          if (op_q == OP_INS && !dup_any && free_any && free_idx == WAY_W'(w)) begin
            we[w]   = 1'b1;
            wkey[w] = '{valid: 1'b1, lf: lf_q, mid: mid_q, spi: spi_q};
            wval[w] = sa_q;
          end
          if (op_q == OP_DEL && owner_ok && way_q == WAY_W'(w)) we[w] = 1'b1;
        end
        S_FLUSH: begin
          we[w]    = (qa[w].lf == lf_q);
          waddr[w] = rd_ptr;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_INIT;
      rd_ptr     <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_set    <= '0;
      rsp_way    <= '0;
      rsp_dup    <= 1'b0;
      op_q       <= '0;
      lf_q       <= '0;
      mid_q      <= '0;
      spi_q      <= '0;
      sa_q       <= '0;
      way_q      <= '0;
      sets_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_INIT: begin
          rd_ptr <= rd_ptr + SET_W'(1);
          if (rd_ptr == '1) state <= S_IDLE;
        end
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          lf_q   <= cmd_lf;
          mid_q  <= cmd_match;
          spi_q  <= cmd_spi;
          sa_q   <= cmd_sa;
          way_q  <= cmd_way;
          sets_q <= ra;
          rd_ptr <= '0;
          state  <= (cmd_op == OP_FLUSH) ? S_FLUSH : S_CHECK;
        end
        S_CHECK: begin
          rsp_valid <= 1'b1;
          rsp_dup   <= 1'b0;
          state     <= S_IDLE;
          if (op_q == OP_INS) begin
            if (dup_any) begin
              rsp_status <= ST_OK;
              rsp_set    <= sets_q[dup_idx];
              rsp_way    <= dup_idx;
              rsp_dup    <= 1'b1;
            end else if (free_any) begin
              rsp_status <= ST_OK;
              rsp_set    <= sets_q[free_idx];
              rsp_way    <= free_idx;
            end else begin
              rsp_status <= ST_FULL;
              rsp_set    <= sets_q[0];
              rsp_way    <= '0;
            end
          end else if (op_q == OP_DEL) begin
            rsp_status <= owner_ok ? ST_OK : ST_OWNER;
            rsp_set    <= sets_q[0];
            rsp_way    <= way_q;
          end else begin
            rsp_status <= ST_BADOP;
            rsp_set    <= '0;
            rsp_way    <= '0;
          end
        end
        S_FLUSH: begin
          rd_ptr <= rd_ptr + SET_W'(1);
          if (rd_ptr == '1) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_set    <= '0;
            rsp_way    <= '0;
            rsp_dup    <= 1'b0;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // data-path lookup: memory read stage, then compare stage
  logic             lk_v1;
  logic [LF_W-1:0]  lk_lf1;
  logic [MID_W-1:0] lk_mid1;
  logic [SPI_W-1:0] lk_spi1;
  logic             lk_any;
  logic [SA_W-1:0]  lk_sel;

  always_comb begin
    lk_any = 1'b0;
    lk_sel = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (qb[w].valid && qb[w].lf == lk_lf1 && qb[w].mid == lk_mid1 && qb[w].spi == lk_spi1) begin
        lk_any = 1'b1;
        lk_sel = qb_val[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v1   <= 1'b0;
      lk_lf1  <= '0;
      lk_mid1 <= '0;
      lk_spi1 <= '0;
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_sa   <= '0;
    end else begin
      lk_v1   <= lk_valid;
      lk_lf1  <= lk_lf;
      lk_mid1 <= lk_match;
      lk_spi1 <= lk_spi;
      lk_done <= lk_v1;
      lk_hit  <= lk_v1 && lk_any;
      lk_sa   <= (lk_v1 && lk_any) ? lk_sel : '0;
    end
  end

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_ready_with_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_ready);
  assert_dup_status_ok_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_dup) |-> rsp_status == ST_OK);
  assert_lookup_latency_R8: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> ##2 lk_done);
  assert_miss_sa_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> lk_sa == '0);
endmodule

// File: tb/spi_sa_table_tb.sv
module spi_sa_table_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_spi = '0;
  logic [15:0] cmd_match = '0;
  logic [6:0]  cmd_lf = '0;
  logic [31:0] cmd_sa = '0;
  logic [10:0] cmd_set = '0;
  logic [1:0]  cmd_way = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [10:0] rsp_set;
  logic [1:0]  rsp_way;
  logic        rsp_dup;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_spi = '0;
  logic [15:0] lk_match = '0;
  logic [6:0]  lk_lf = '0;
  logic        lk_done;
  logic        lk_hit;
  logic [31:0] lk_sa;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  spi_sa_table u_dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // set index per R2, from the requirement text
  function automatic logic [10:0] bset(input logic [6:0] lf, input logic [15:0] mid,
                                       input logic [31:0] spi, input int w);
    logic [54:0] k;
    logic [10:0] f;
    logic [10:0] s;
    k = {lf, mid, spi};
    f = '0;
    for (int i = 0; i < 55; i++) f[i % 11] = f[i % 11] ^ k[i];
    for (int b = 0; b < 11; b++) s[b] = f[(b + 3 * w) % 11];
    return s;
  endfunction

  typedef struct packed {
    logic [31:0] spi;
    logic [15:0] mid;
    logic [6:0]  lf;
    logic [31:0] sa;
    logic [1:0]  st;
    logic        dup;
    logic [1:0]  way;
  } vec_t;

  localparam logic [31:0] KA = 32'h1234_5678;
  localparam vec_t VECS [8] = '{
    '{KA,                 16'h00AB, 7'd5, 32'd100, 2'd0, 1'b0, 2'd0},
    '{KA ^ 32'h0000_0801, 16'h00AB, 7'd5, 32'd101, 2'd0, 1'b0, 2'd1},
    '{KA,                 16'h00AB, 7'd5, 32'd999, 2'd0, 1'b1, 2'd0},
    '{KA ^ 32'h0000_1002, 16'h00AB, 7'd5, 32'd102, 2'd0, 1'b0, 2'd2},
    '{KA ^ 32'h0000_2004, 16'h00AB, 7'd5, 32'd103, 2'd0, 1'b0, 2'd3},
    '{KA ^ 32'h0000_4008, 16'h00AB, 7'd5, 32'd104, 2'd1, 1'b0, 2'd0},
    '{32'hCAFE_0001,      16'h0002, 7'd9, 32'd200, 2'd0, 1'b0, 2'd0},
    '{32'h0BAD_F00D,      16'h0003, 7'd9, 32'd300, 2'd0, 1'b0, 2'd0}
  };

  logic [1:0]  r_st;
  logic [10:0] r_set;
  logic [1:0]  r_way;
  logic        r_dup;
  int          r_lat;

  task automatic run_cmd(input logic [1:0] op, input logic [31:0] spi, input logic [15:0] mid,
                         input logic [6:0] lf, input logic [31:0] sa,
                         input logic [10:0] set, input logic [1:0] way);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_spi = spi; cmd_match = mid; cmd_lf = lf;
    cmd_sa = sa; cmd_set = set; cmd_way = way; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_lat = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      r_lat++;
    end
    r_st = rsp_status; r_set = rsp_set; r_way = rsp_way; r_dup = rsp_dup;
  endtask

  logic        l_hit;
  logic [31:0] l_sa;

  task automatic lookup(input logic [31:0] spi, input logic [15:0] mid, input logic [6:0] lf);
    @(negedge clk);
    lk_valid = 1'b1; lk_spi = spi; lk_match = mid; lk_lf = lf;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_done == 1'b0, "R8 done early", longint'(lk_done), 0);
    @(negedge clk);
    chk(lk_done == 1'b1, "R8 latency", longint'(lk_done), 1);
    l_hit = lk_hit; l_sa = lk_sa;
  endtask

  initial begin
    int n;
    logic [31:0] k1s, k4s;
    k1s = KA ^ 32'h0000_0801;
    k4s = KA ^ 32'h0000_4008;

    // R1: reset state and init sweep length
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && lk_done == 0, "R1 reset outputs", {rsp_valid, lk_done}, 0);
    chk(cmd_ready == 0, "R1 ready in reset", longint'(cmd_ready), 0);
    rst = 1'b0;
    n = 0;
    while (!cmd_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 2048, "R1 init sweep cycles", n, 2048);
    lookup(KA, 16'h00AB, 7'd5);
    chk(l_hit == 0 && l_sa == 0, "R1 empty after init", {l_hit, l_sa}, 0);

    // R2..R5 table of inserts on one colliding set
    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic logic [10:0] es = bset(v.lf, v.mid, v.spi, int'(v.way));
      run_cmd(2'd0, v.spi, v.mid, v.lf, v.sa, '0, '0);
      chk(r_lat == 1, "R3 response latency", r_lat, 1);
      chk(r_st == v.st, "R3/R4/R5 status", r_st, v.st);
      chk(r_dup == v.dup, "R4 dup flag", r_dup, v.dup);
      chk(r_way == v.way, "R3 way order", r_way, v.way);
      chk(r_set == es, "R2 set index", r_set, es);
    end

    // lookups after inserts
    lookup(KA ^ 32'h0000_1002, 16'h00AB, 7'd5);
    chk(l_hit && l_sa == 102, "R8 hit way2", l_sa, 102);
    lookup(KA, 16'h00AB, 7'd5);
    chk(l_hit && l_sa == 100, "R4 dup did not overwrite", l_sa, 100);
    lookup(k4s, 16'h00AB, 7'd5);
    chk(!l_hit && l_sa == 0, "R5 full wrote nothing", {l_hit, l_sa}, 0);
    lookup(32'hCAFE_0001, 16'h0002, 7'd9);
    chk(l_hit && l_sa == 200, "R8 hit other key", l_sa, 200);
    lookup(32'hCAFE_0001, 16'h0002, 7'd8);
    chk(!l_hit, "R8 lf is part of key", longint'(l_hit), 0);

    // R6 delete with wrong owner, then right owner
    run_cmd(2'd1, '0, '0, 7'd4, '0, bset(7'd5, 16'h00AB, k1s, 1), 2'd1);
    chk(r_st == 2'd2, "R6 not owner status", r_st, 2);
    lookup(k1s, 16'h00AB, 7'd5);
    chk(l_hit && l_sa == 101, "R6 refused delete kept entry", l_sa, 101);
    run_cmd(2'd1, '0, '0, 7'd5, '0, bset(7'd5, 16'h00AB, k1s, 1), 2'd1);
    chk(r_st == 2'd0 && r_way == 2'd1, "R6 delete ok", {r_st, r_way}, 1);
    lookup(k1s, 16'h00AB, 7'd5);
    chk(!l_hit, "R6 entry cleared", longint'(l_hit), 0);

    // R9 lookup on the write edge sees old contents, next edge sees new
    @(negedge clk);
    cmd_op = 2'd0; cmd_spi = k4s; cmd_match = 16'h00AB; cmd_lf = 7'd5;
    cmd_sa = 32'd104; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lk_valid = 1'b1; lk_spi = k4s; lk_match = 16'h00AB; lk_lf = 7'd5;
    @(negedge clk);
    chk(rsp_valid && rsp_way == 2'd1 && rsp_status == 2'd0, "R3 reuse freed way1",
        {rsp_valid, rsp_way}, 5);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_done && !lk_hit, "R9 same-edge lookup sees old", longint'(lk_hit), 0);
    @(negedge clk);
    chk(lk_done && lk_hit && lk_sa == 104, "R9 next lookup sees new", lk_sa, 104);

    // R7 flush of lf 9
    run_cmd(2'd2, '0, '0, 7'd9, '0, '0, '0);
    chk(r_lat == 2048 && r_st == 2'd0, "R7 flush duration", r_lat, 2048);
    lookup(32'hCAFE_0001, 16'h0002, 7'd9);
    chk(!l_hit, "R7 flushed entry gone", longint'(l_hit), 0);
    lookup(32'h0BAD_F00D, 16'h0003, 7'd9);
    chk(!l_hit, "R7 second flushed entry gone", longint'(l_hit), 0);
    lookup(KA ^ 32'h0000_2004, 16'h00AB, 7'd5);
    chk(l_hit && l_sa == 103, "R7 other owner kept", l_sa, 103);

    // R11 invalid op
    run_cmd(2'd3, KA, 16'h00AB, 7'd5, 32'd777, '0, '0);
    chk(r_st == 2'd3, "R11 bad op status", r_st, 3);
    lookup(KA, 16'h00AB, 7'd5);
    chk(l_hit && l_sa == 100, "R11 table unchanged", l_sa, 100);

    // R10 ready drops while busy and returns with response
    @(negedge clk);
    cmd_op = 2'd0; cmd_spi = 32'h5555_0000; cmd_match = 16'h1; cmd_lf = 7'd3;
    cmd_sa = 32'd55; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R10 busy after accept", longint'(cmd_ready), 0);
    @(negedge clk);
    chk(cmd_ready && rsp_valid, "R10 ready with response", {cmd_ready, rsp_valid}, 3);
    @(negedge clk);
    chk(!rsp_valid, "R10 single pulse", longint'(rsp_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule